// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block picks which of eight interrupt sources is acknowledged next and decides when a new request may interrupt a handler that is already running. Each source has a two-bit priority level, where 0 is the most urgent and 3 the least. Each source also has a fixed rank given by its index, where index 0 ranks highest. The block records which levels are in service in a four-bit mask. A new maskable request wins only if it outranks the level currently being served. A nesting-lock input decides whether a level-3 handler can be interrupted by another level-3 request.

A source can instead be marked as fast-service. A fast-service request is acknowledged at once, whatever the enable flag, the in-service levels or other pending work. It does not enter the in-service mask.

Software drives three inputs:
- a set strobe for the global enable flag;
- a clear strobe for the global enable flag;
- a return strobe that ends the most urgent handler in service.

The block answers with a one-cycle acknowledge pulse that carries the source index and the kind of service.

Top module: `nipc_top`

## Requirements
- R1: After reset no acknowledge is issued, the in-service mask is empty and the enable flag is clear, so a maskable request raised straight after reset stays unacknowledged.
- R2: A maskable request is acknowledged only while the enable flag is set. `enSet` sets the flag and `enClr` clears it. Every maskable acknowledge also clears it, and that clear overrides an `enSet` in the same cycle.
- R3: While the in-service mask is non-empty, a maskable request is accepted only if its level is numerically below the current level. The current level is the lowest-numbered set bit of the mask. A request at an equal or higher level number is held pending, and this includes level 0 during a level-0 handler.
- R4: With `nestLock` = 1, a level-3 request is not accepted while level 3 is the current level.
- R5: With `nestLock` = 0, a level-3 request is accepted while level 3 is the current level.
- R6: A source whose `fastMode` bit is 1 is acknowledged with `ackFast` = 1 regardless of the enable flag, the in-service mask or any pending maskable request. Fast-service requests take precedence over maskable ones, the lowest index wins among them, and they change neither the mask nor the enable flag.
- R7: Among pending maskable requests, the lowest level number wins. On equal levels the lowest source index wins, whatever order the requests arrived in.
- R8: A one-cycle pulse on `reqIn[i]` is latched as pending until source i is acknowledged. A held request is acknowledged once the conditions of R2 and R3 allow it.
- R9: Each `retStrobe` clears the lowest-numbered set bit of the in-service mask. An empty mask means the main routine is running, and any enabled maskable request may then win.
- R10: An acknowledge is a single-cycle `ackValid` pulse with `ackIdx` and `ackFast`, issued on the second rising edge after the request is sampled. A maskable acknowledge sets the mask bit of the source's level, where the level of source i is `srcLevel[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 8 | Request pulses, one per source |
| fastMode | input | 8 | Per-source fast-service selection |
| srcLevel | input | 16 | Two-bit level per source; source i at bits 2i+1:2i |
| nestLock | input | 1 | 1 forbids level-3 nesting within level 3 |
| enSet | input | 1 | Sets the global enable flag |
| enClr | input | 1 | Clears the global enable flag |
| retStrobe | input | 1 | Ends the most urgent handler in service |
| ackValid | output | 1 | Acknowledge pulse |
| ackIdx | output | 3 | Index of the acknowledged source |
| ackFast | output | 1 | 1 for a fast-service acknowledge, 0 for a maskable one |

## Verification
The acknowledge output is registered, and arbitration reads only registered state. A request, an enable set or a return strobe sampled on one rising edge therefore shows up at the outputs just after the second rising edge that follows it. The reference model is updated on every rising edge from the inputs held over that edge, and it is compared with the outputs at each falling edge, so its predictions line up with that two-edge delay. Directed checks drive each stimulus for one cycle from a falling edge. They then look for the first acknowledge within a short window of falling edges, or confirm that none arrives in a window longer than the two-edge delay.

// File: rtl/nipc_pkg.sv
package nipc_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef struct packed {
    logic grant;     // acknowledge this cycle
    logic fast;      // winner is the fast-service candidate
    logic popLevel;  // drop the most urgent in-service level
    logic setEn;     // raise the enable flag
    logic clrEn;     // drop the enable flag
  } ctlStrobe_t;
endpackage

// File: rtl/nipc_datapath.sv
module nipc_datapath
  import nipc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqIn,
  input  logic [NUM_SRC-1:0]       fastMode,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  ctlStrobe_t               strobe,
  output logic                     fastAny,
  output logic                     maskAny,
  output logic [LVL_W-1:0]         maskLevel,
  output logic                     curIdle,
  output logic [LVL_W-1:0]         curLevel,
  output logic                     enFlag,
  output logic                     ackValid,
  output logic [IDX_W-1:0]         ackIdx,
  output logic                     ackFast
);
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_LVL-1:0] inServQ;
  logic               enQ;
  logic [LVL_W-1:0]   lvlArr [NUM_SRC];
  logic [NUM_SRC-1:0] fastCand, maskCand, takeMask;
  logic [IDX_W-1:0]   fastIdx, maskIdx, grantIdx;
  logic [NUM_LVL-1:0] popBit, servNext;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gLvl
      assign lvlArr[g] = srcLevel[g*LVL_W +: LVL_W];
    end
  endgenerate

  assign fastCand = pendQ & fastMode;
  assign maskCand = pendQ & ~fastMode;

  // fast candidates: lowest index wins
  always_comb begin
    fastAny = 1'b0;
    fastIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fastCand[i]) begin
        fastAny = 1'b1;
        fastIdx = IDX_W'(i);
      end
    end
  end

  // maskable candidates: lowest level, then lowest index
  always_comb begin
    maskAny   = 1'b0;
    maskIdx   = '0;
    maskLevel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (maskCand[i] && (!maskAny || lvlArr[i] <= maskLevel)) begin
        maskAny   = 1'b1;
        maskIdx   = IDX_W'(i);
        maskLevel = lvlArr[i];
      end
    end
  end

  // current level is the most urgent level in service
  always_comb begin
    curLevel = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (inServQ[l]) curLevel = LVL_W'(l);
    end
  end
  assign curIdle = (inServQ == '0);
  assign enFlag  = enQ;

  assign grantIdx = strobe.fast ? fastIdx : maskIdx;
  assign takeMask = strobe.grant ? (NUM_SRC'(1) << grantIdx) : '0;
  assign popBit   = inServQ & (~inServQ + NUM_LVL'(1));

  always_comb begin
    servNext = inServQ;
    if (strobe.popLevel) servNext = servNext & ~popBit;
    if (strobe.grant && !strobe.fast) servNext = servNext | (NUM_LVL'(1) << maskLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      inServQ  <= '0;
      enQ      <= 1'b0;
      ackValid <= 1'b0;
      ackIdx   <= '0;
      ackFast  <= 1'b0;
    end else begin
      pendQ    <= (pendQ & ~takeMask) | reqIn;
      inServQ  <= servNext;
      if (strobe.clrEn)      enQ <= 1'b0;
      else if (strobe.setEn) enQ <= 1'b1;
      ackValid <= strobe.grant;
      ackIdx   <= strobe.grant ? grantIdx : '0;
      ackFast  <= strobe.grant && strobe.fast;
    end
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant |-> pendQ[grantIdx]); // R8
  AST_MASK_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant && !strobe.fast |=> !enQ); // R2
  AST_FAST_KEEPS_SERV: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant && strobe.fast && !strobe.popLevel |=> $stable(inServQ)); // R6
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popLevel && (inServQ != '0) && !(strobe.grant && !strobe.fast)
    |=> $countones(inServQ) == $countones($past(inServQ)) - 1); // R9
endmodule

// File: rtl/nipc_control.sv
module nipc_control
  import nipc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastAny,
  input  logic             maskAny,
  input  logic [LVL_W-1:0] maskLevel,
  input  logic             curIdle,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             enFlag,
  input  logic             nestLock,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             retStrobe,
  output ctlStrobe_t       strobe
);
  localparam logic [LVL_W-1:0] LOWEST = LVL_W'(NUM_LVL - 1);

  logic levelOk, sameLowest, maskWin;

  assign sameLowest = (maskLevel == LOWEST) && (curLevel == LOWEST);
  assign levelOk    = curIdle || (maskLevel < curLevel) || (sameLowest && !nestLock);
  assign maskWin    = maskAny && enFlag && levelOk;

  always_comb begin
    strobe          = '0;
    strobe.fast     = fastAny;
    strobe.grant    = fastAny || maskWin;
    strobe.popLevel = retStrobe;
    strobe.setEn    = enSet;
    strobe.clrEn    = enClr || (maskWin && !fastAny);
  end

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant && !strobe.fast |-> enFlag); // R2
  AST_LOCK_NO_SAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant && !strobe.fast && nestLock && !curIdle |-> maskLevel != curLevel); // R4
endmodule

// File: rtl/nipc_top.sv
module nipc_top
  import nipc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  reqIn,
  input  logic [7:0]  fastMode,
  input  logic [15:0] srcLevel,
  input  logic        nestLock,
  input  logic        enSet,
  input  logic        enClr,
  input  logic        retStrobe,
  output logic        ackValid,
  output logic [2:0]  ackIdx,
  output logic        ackFast
);
  ctlStrobe_t       strobe;
  logic             fastAny, maskAny, curIdle, enFlag;
  logic [LVL_W-1:0] maskLevel, curLevel;

  nipc_datapath #(.NUM_SRC(8)) uDp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .fastMode(fastMode), .srcLevel(srcLevel),
    .strobe(strobe), .fastAny(fastAny), .maskAny(maskAny), .maskLevel(maskLevel),
    .curIdle(curIdle), .curLevel(curLevel), .enFlag(enFlag),
    .ackValid(ackValid), .ackIdx(ackIdx), .ackFast(ackFast)
  );

  nipc_control uCtl (
    .clk(clk), .rstN(rstN), .fastAny(fastAny), .maskAny(maskAny), .maskLevel(maskLevel),
    .curIdle(curIdle), .curLevel(curLevel), .enFlag(enFlag), .nestLock(nestLock),
    .enSet(enSet), .enClr(enClr), .retStrobe(retStrobe), .strobe(strobe)
  );
endmodule

// File: tb/sim_nipc_top.sv
`timescale 1ns/1ps
module sim_nipc_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] reqIn = '0, fastMode = '0;
  logic [15:0] srcLevel = '0;
  logic nestLock = 1'b1, enSet = 1'b0, enClr = 1'b0, retStrobe = 1'b0;
  logic ackValid, ackFast;
  logic [2:0] ackIdx;

  int compared = 0, mismatched = 0;
  string curTag = "R10";

  int mPend[8];
  int mIns[4];
  int mEn, expV, expIdx, expF;
  int lvlOf[8] = '{2, 0, 3, 3, 0, 1, 2, 2};

  always #2.5 clk = ~clk;

  nipc_top u0 (.clk(clk), .rstN(rstN), .reqIn(reqIn), .fastMode(fastMode),
    .srcLevel(srcLevel), .nestLock(nestLock), .enSet(enSet), .enClr(enClr),
    .retStrobe(retStrobe), .ackValid(ackValid), .ackIdx(ackIdx), .ackFast(ackFast));

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mPend[i]) mPend[i] = 0;
      foreach (mIns[i]) mIns[i] = 0;
      mEn = 0; expV = 0; expIdx = 0; expF = 0;
    end else begin
      int win, wf, cur, best;
      win = -1; wf = 0; cur = 4; best = 9;
      for (int i = 7; i >= 0; i--) if (mPend[i] != 0 && fastMode[i]) begin win = i; wf = 1; end
      if (win < 0 && mEn != 0) begin
        for (int l = 3; l >= 0; l--) if (mIns[l] != 0) cur = l;
        for (int i = 0; i < 8; i++)
          if (mPend[i] != 0 && !fastMode[i] && lvlOf[i] < best) begin best = lvlOf[i]; win = i; end
        if (win >= 0 && !(cur == 4 || best < cur || (best == 3 && cur == 3 && !nestLock))) win = -1;
      end
      if (retStrobe) begin
        for (int l = 0; l < 4; l++) if (mIns[l] != 0) begin mIns[l] = 0; break; end
      end
      if (win >= 0 && wf == 0) mIns[lvlOf[win]] = 1;
      if (enSet) mEn = 1;
      if (enClr || (win >= 0 && wf == 0)) mEn = 0;
      if (win >= 0) mPend[win] = 0;
      for (int i = 0; i < 8; i++) if (reqIn[i]) mPend[i] = 1;
      expV = (win >= 0); expIdx = (win >= 0) ? win : 0; expF = wf;
    end
  end

  always @(negedge clk) if (rstN) begin
    compared++;
    if (ackValid !== expV[0] || ackIdx !== expIdx[2:0] || ackFast !== expF[0]) begin
      mismatched++;
      $display("FAIL %s model: got v=%0b idx=%0d f=%0b, expected v=%0d idx=%0d f=%0d",
               curTag, ackValid, ackIdx, ackFast, expV, expIdx, expF);
    end
  end

  task automatic drive(input logic [7:0] r, input logic es, input logic ec, input logic rt);
    @(negedge clk);
    reqIn = r; enSet = es; enClr = ec; retStrobe = rt;
    @(negedge clk);
    reqIn = '0; enSet = 1'b0; enClr = 1'b0; retStrobe = 1'b0;
  endtask

  task automatic expectAck(input int idx, input int f, input string tag);
    curTag = tag;
    compared++;
    for (int n = 0; n < 8; n++) begin
      if (ackValid) begin
        if (ackIdx !== idx[2:0] || ackFast !== f[0]) begin
          mismatched++;
          $display("FAIL %s ack: got idx=%0d f=%0b, expected idx=%0d f=%0d", tag, ackIdx, ackFast, idx, f);
        end
        return;
      end
      @(negedge clk);
    end
    mismatched++;
    $display("FAIL %s ack: got none, expected idx=%0d f=%0d", tag, idx, f);
  endtask

  task automatic expectNone(input int n, input string tag);
    curTag = tag;
    compared++;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ackValid) begin
        mismatched++;
        $display("FAIL %s hold: got ack idx=%0d, expected none", tag, ackIdx);
        return;
      end
    end
  endtask

  initial begin
    #500000;
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) srcLevel[2*i +: 2] = lvlOf[i][1:0];
    fastMode = 8'b0100_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectNone(3, "R1");
    drive(8'h80, 0, 0, 0);                 // src7 L2, enable still clear
    expectNone(5, "R1");
    drive(8'h00, 1, 0, 0);
    expectAck(7, 0, "R2");
    drive(8'h20, 0, 0, 0);                 // src5 L1, enable auto-cleared
    expectNone(5, "R2");
    drive(8'h00, 1, 0, 0);
    expectAck(5, 0, "R3");                 // L1 preempts L2
    drive(8'h01, 1, 0, 0);                 // src0 L2 during L1
    expectNone(5, "R3");
    drive(8'h40, 0, 0, 0);                 // fast src6
    expectAck(6, 1, "R6");
    drive(8'h00, 0, 0, 1);                 // back to L2: src0 still held
    expectNone(5, "R9");
    drive(8'h00, 0, 0, 1);                 // main routine
    expectAck(0, 0, "R8");
    drive(8'h00, 0, 0, 1);
    drive(8'h08, 0, 0, 0);                 // src3 L3 first
    drive(8'h04, 0, 0, 0);                 // src2 L3 later
    expectNone(3, "R7");
    drive(8'h00, 1, 0, 0);
    expectAck(2, 0, "R7");
    drive(8'h00, 1, 0, 0);
    expectNone(5, "R4");
    @(negedge clk) nestLock = 1'b0;
    expectAck(3, 0, "R5");
    @(negedge clk) nestLock = 1'b1;
    drive(8'h00, 0, 0, 1);
    drive(8'h02, 1, 0, 0);                 // src1 L0 from main
    expectAck(1, 0, "R10");
    drive(8'h10, 1, 0, 0);                 // src4 L0 during L0
    expectNone(5, "R3");
    drive(8'h40, 0, 0, 0);                 // fast while src4 pending
    expectAck(6, 1, "R6");
    drive(8'h00, 0, 1, 0);                 // clear enable
    drive(8'h00, 0, 0, 1);
    expectNone(5, "R2");
    drive(8'h00, 1, 0, 0);
    expectAck(4, 0, "R8");
    drive(8'h00, 0, 0, 1);
    curTag = "R10";
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule